// File: doc/BRIEF.md
# Low-Power State and Oscillator Restart Controller

This controller sits next to a processor core and chooses the low-power state the core enters when it executes its sleep instruction. A small control register holds a two-bit mode field, a bus-request enable bit, a clock-divide bit and a reduced-drive flag. When a sleep strobe arrives, the controller combines the mode field with an external I/O-stop flag and picks one of the following states: plain sleep, system stop, idle, standby, or quick-recovery standby. For the chosen state it drives an oscillator enable and a core clock gate.

When a wake event arrives in a state whose oscillator has kept running, the controller returns to normal clocking on the next cycle. When a wake event arrives in either standby state, the controller first turns the oscillator back on. It then runs a stabilization counter, which is long for standby and short for quick-recovery standby. Normal clocking and the ready flag come back only when that counter expires.

While in standby, an external bus request can be honored when the enable bit allows it. The request restarts the oscillator and runs the same counter. The bus grant is given only after the counter expires, and dropping the request puts the oscillator back to sleep.

Top module: `pwrdn_ctrl`

## Requirements
- R1: After a synchronous reset the control register is all zero and mode_status reads 0 (running), with osc_en=1, clk_run=1, ready=1 and bus_grant_ok=0. The mode_status codes are: 0 running, 1 sleep, 2 system stop, 3 idle, 4 standby, 5 quick standby, 6 wake restart, 7 bus warm-up, 8 bus hold.
- R2: Writing reg_wdata bit 0 sets div_bypass on the cycle after the write. A value of 0 means the master clock is the input divided by two, and 1 means the input is used undivided.
- R3: The mode field is reg_wdata bits 2:1 (bit 2 upper). In the running state a sleep strobe with io_stop=0 enters sleep (1) for any mode. With mode 00 and io_stop=1 it enters system stop (2). In both states osc_en and clk_run stay 1.
- R4: Mode 01 with io_stop=1 enters idle (3), with osc_en=1 and clk_run=0. A wake event returns the controller to running, with ready=1, one cycle later and without any stabilization delay.
- R5: Mode 10 with io_stop=1 enters standby (4) with osc_en=0. A wake event moves to wake restart (6) with osc_en=1. Running resumes exactly LONG_CYC cycles after that (default 131072).
- R6: Mode 11 with io_stop=1 enters quick standby (5) with osc_en=0. After a wake event, running resumes exactly SHORT_CYC cycles after the restart begins (default 64).
- R7: clk_run is 0 in idle, in both standby states and in every restart or bus state. ready is 1 only in the running state.
- R8: With reg_wdata bit 3 (bus-request enable) at 1, a bus_req in a standby state enters bus warm-up (7) with osc_en=1 and no grant. bus_grant_ok rises when the mode's stabilization count expires (bus hold, 8). Dropping bus_req returns to the same standby state with osc_en=0. A wake during bus hold goes straight to running.
- R9: With the bus-request enable at 0, bus_req in a standby state has no effect: the state, osc_en=0 and bus_grant_ok=0 all hold.
- R10: Outside the standby, restart and bus states, bus_grant_ok follows bus_req one cycle later.
- R11: Writing reg_wdata bit 4 drives low_drive on the cycle after the write.
- R12: A sleep strobe is ignored in every state except running, and a wake event is ignored while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 5 | Control register write data |
| sleep_exec | input | 1 | Core executed its sleep instruction |
| io_stop | input | 1 | I/O-stop flag sampled with the sleep strobe |
| wake | input | 1 | Enabled wake event (interrupt or reset request) |
| bus_req | input | 1 | External bus request |
| osc_en | output | 1 | Oscillator enable |
| clk_run | output | 1 | Core clock gate open |
| div_bypass | output | 1 | 1: master clock undivided, 0: divided by two |
| low_drive | output | 1 | Reduced clock-output drive request |
| bus_grant_ok | output | 1 | Bus grant permitted |
| ready | output | 1 | Normal clocking active |
| mode_status | output | 4 | Current state code |

## Verification
The embedded properties check the following on every cycle:
- the entry into each standby variant from the mode field,
- the one-cycle return from idle,
- that a wake in standby always starts a restart,
- that a restart never exits early,
- that the restart counter never exceeds its limit,
- that a bus request without the enable bit leaves standby untouched,
- that a grant never appears while the oscillator is still settling.

The exact length of each restart window, the timing of the bus grant after warm-up, the return to the correct standby variant when the request drops, and the side outputs can only be shown by the bench's directed and random scenarios. These scenarios are compared against a cycle model.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

  localparam int CTL_W = 5;

  typedef enum logic [3:0] {
    PS_RUN     = 4'd0,
    PS_SLEEP   = 4'd1,
    PS_SYSSTOP = 4'd2,
    PS_IDLE    = 4'd3,
    PS_STBY    = 4'd4,
    PS_QSTBY   = 4'd5,
    PS_WARM    = 4'd6,
    PS_BWARM   = 4'd7,
    PS_BHOLD   = 4'd8
  } pstate_e;

  // field order mirrors write-data bit order (bit 4 .. bit 0)
  typedef struct packed {
    logic low_drive;
    logic bus_en;
    logic mode_hi;
    logic mode_lo;
    logic div_bypass;
  } ctl_t;

  function automatic logic is_warm(pstate_e s);
    return (s == PS_WARM) || (s == PS_BWARM);
  endfunction

  function automatic logic is_awake(pstate_e s);
    return (s == PS_RUN) || (s == PS_SLEEP) || (s == PS_SYSSTOP) || (s == PS_IDLE);
  endfunction

endpackage

// File: rtl/pwrdn_regs.sv
module pwrdn_regs
  import pwrdn_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output logic [1:0]       mode,
  output logic             bus_en,
  output logic             div_bypass,
  output logic             low_drive
);

  ctl_t ctl_q;

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else if (we) ctl_q <= ctl_t'(wdata);
  end

  assign mode       = {ctl_q.mode_hi, ctl_q.mode_lo};
  assign bus_en     = ctl_q.bus_en;
  assign div_bypass = ctl_q.div_bypass;
  assign low_drive  = ctl_q.low_drive;

endmodule

// File: rtl/pwrdn_stab_timer.sv
module pwrdn_stab_timer #(
  parameter int LONG_CYC  = 131072,
  parameter int SHORT_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic active,  // current state is a warm-up state
  input  logic keep,    // next state stays in warm-up
  input  logic quick,
  output logic expire
);

  localparam int CW = (LONG_CYC > 1) ? $clog2(LONG_CYC) : 1;
  localparam logic [CW-1:0] LONG_TC  = CW'(LONG_CYC - 1);
  localparam logic [CW-1:0] SHORT_TC = CW'(SHORT_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] tc;

  assign tc     = quick ? SHORT_TC : LONG_TC;
  assign expire = active && (cnt_q == tc);

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (active && keep) cnt_q <= cnt_q + 1'b1;
    else                    cnt_q <= '0;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LONG_TC);  // R5
  AST_QUICK_BOUND: assert property (@(posedge clk) disable iff (rst)
    (active && quick) |-> cnt_q <= SHORT_TC);  // R6

endmodule

// File: rtl/pwrdn_fsm.sv
module pwrdn_fsm
  import pwrdn_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       bus_en,
  input  logic       sleep_exec,
  input  logic       io_stop,
  input  logic       wake,
  input  logic       bus_req,
  input  logic       expire,
  output pstate_e    state_q,
  output pstate_e    state_d,
  output logic       quick_q
);

  pstate_e stby_home;
  pstate_e deep_pick;

  assign stby_home = quick_q ? PS_QSTBY : PS_STBY;

  always_comb begin
    unique case (mode)
      2'b00:   deep_pick = PS_SYSSTOP;
      2'b01:   deep_pick = PS_IDLE;
      2'b10:   deep_pick = PS_STBY;
      default: deep_pick = PS_QSTBY;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_RUN:
        if (sleep_exec) state_d = io_stop ? deep_pick : PS_SLEEP;
      PS_SLEEP, PS_SYSSTOP, PS_IDLE:
        if (wake) state_d = PS_RUN;
      PS_STBY, PS_QSTBY:
        if (wake) state_d = PS_WARM;
        else if (bus_en && bus_req) state_d = PS_BWARM;
      PS_WARM:
        if (expire) state_d = PS_RUN;
      PS_BWARM:
        if (expire) state_d = wake ? PS_RUN : (bus_req ? PS_BHOLD : stby_home);
        else if (wake) state_d = PS_WARM;
        else if (!bus_req) state_d = stby_home;
      PS_BHOLD:
        if (wake) state_d = PS_RUN;
        else if (!bus_req) state_d = stby_home;
      default: state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PS_RUN;
      quick_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == PS_RUN && state_d == PS_STBY)  quick_q <= 1'b0;
      if (state_q == PS_RUN && state_d == PS_QSTBY) quick_q <= 1'b1;
    end
  end

  AST_STBY_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_RUN && sleep_exec && io_stop && mode == 2'b10) |=> state_q == PS_STBY);  // R5
  AST_QSTBY_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_RUN && sleep_exec && io_stop && mode == 2'b11) |=> state_q == PS_QSTBY);  // R6
  AST_IDLE_FAST_WAKE: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_IDLE && wake) |=> state_q == PS_RUN);  // R4
  AST_STBY_WAKE_RESTART: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_STBY && wake) |=> state_q == PS_WARM);  // R5
  AST_WARM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_WARM && !expire) |=> state_q == PS_WARM);  // R7
  AST_NO_BUS_WAKE: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_STBY && !bus_en && !wake) |=> state_q == PS_STBY);  // R9
  AST_SLEEP_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_SLEEP && !wake) |=> state_q == PS_SLEEP);  // R12

endmodule

// File: rtl/pwrdn_outreg.sv
module pwrdn_outreg
  import pwrdn_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  pstate_e    state_d,
  input  logic       bus_req,
  output logic       osc_en,
  output logic       clk_run,
  output logic       ready,
  output logic       grant,
  output logic [3:0] status
);

  always_ff @(posedge clk) begin
    if (rst) begin
      osc_en  <= 1'b1;
      clk_run <= 1'b1;
      ready   <= 1'b1;
      grant   <= 1'b0;
      status  <= PS_RUN;
    end else begin
      osc_en  <= !(state_d == PS_STBY || state_d == PS_QSTBY);
      clk_run <= (state_d == PS_RUN) || (state_d == PS_SLEEP) || (state_d == PS_SYSSTOP);
      ready   <= (state_d == PS_RUN);
      grant   <= (state_d == PS_BHOLD) || (bus_req && is_awake(state_d));
      status  <= state_d;
    end
  end

  AST_GRANT_SETTLED: assert property (@(posedge clk) disable iff (rst)
    grant |-> (status != PS_WARM && status != PS_BWARM && status != PS_STBY && status != PS_QSTBY));  // R8
  AST_OSC_OFF_NO_CLOCK: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> !clk_run);  // R7

endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
  import pwrdn_pkg::*;
#(
  parameter int LONG_CYC  = 131072,
  parameter int SHORT_CYC = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [CTL_W-1:0] reg_wdata,
  input  logic             sleep_exec,
  input  logic             io_stop,
  input  logic             wake,
  input  logic             bus_req,
  output logic             osc_en,
  output logic             clk_run,
  output logic             div_bypass,
  output logic             low_drive,
  output logic             bus_grant_ok,
  output logic             ready,
  output logic [3:0]       mode_status
);

  logic [1:0] mode;
  logic       bus_en;
  logic       expire;
  logic       quick_q;
  pstate_e    state_q;
  pstate_e    state_d;

  pwrdn_regs u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .wdata(reg_wdata),
    .mode(mode), .bus_en(bus_en), .div_bypass(div_bypass), .low_drive(low_drive)
  );

  pwrdn_fsm u_fsm (
    .clk(clk), .rst(rst), .mode(mode), .bus_en(bus_en),
    .sleep_exec(sleep_exec), .io_stop(io_stop), .wake(wake), .bus_req(bus_req),
    .expire(expire), .state_q(state_q), .state_d(state_d), .quick_q(quick_q)
  );

  pwrdn_stab_timer #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_timer (
    .clk(clk), .rst(rst),
    .active(is_warm(state_q)), .keep(is_warm(state_d)),
    .quick(quick_q), .expire(expire)
  );

  pwrdn_outreg u_out (
    .clk(clk), .rst(rst), .state_d(state_d), .bus_req(bus_req),
    .osc_en(osc_en), .clk_run(clk_run), .ready(ready),
    .grant(bus_grant_ok), .status(mode_status)
  );

endmodule

// File: tb/test_pwrdn_ctrl.sv
module test_pwrdn_ctrl;

  localparam int LONG  = 200;
  localparam int SHORT = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [4:0] reg_wdata = '0;
  logic       sleep_exec = 1'b0, io_stop = 1'b0, wake = 1'b0, bus_req = 1'b0;
  logic       osc_en, clk_run, div_bypass, low_drive, bus_grant_ok, ready;
  logic [3:0] mode_status;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #5 clk = ~clk;

  pwrdn_ctrl #(.LONG_CYC(LONG), .SHORT_CYC(SHORT)) i_pwrdn_ctrl (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .sleep_exec(sleep_exec), .io_stop(io_stop), .wake(wake), .bus_req(bus_req),
    .osc_en(osc_en), .clk_run(clk_run), .div_bypass(div_bypass), .low_drive(low_drive),
    .bus_grant_ok(bus_grant_ok), .ready(ready), .mode_status(mode_status)
  );

  // reference model state
  int         m_st = 0;
  int         m_cnt = 0;
  bit         m_quick = 0;
  logic [4:0] m_ctl = '0;
  int e_osc = 1, e_run = 1, e_ready = 1, e_grant = 0, e_st = 0;

  function automatic bit warm(int s);
    return (s == 6) || (s == 7);
  endfunction

  function automatic bit awake(int s);
    return s <= 3;
  endfunction

  task automatic model_step();
    int ns;
    int lim;
    int home;
    bit ex;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_quick = 0; m_ctl = '0;
      e_osc = 1; e_run = 1; e_ready = 1; e_grant = 0; e_st = 0;
    end else begin
      lim  = m_quick ? SHORT : LONG;
      ex   = warm(m_st) && (m_cnt == lim - 1);
      home = m_quick ? 5 : 4;
      ns   = m_st;
      case (m_st)
        0: if (sleep_exec) ns = !io_stop ? 1 : 2 + int'(m_ctl[2:1]);
        1, 2, 3: if (wake) ns = 0;
        4, 5: if (wake) ns = 6; else if (m_ctl[3] && bus_req) ns = 7;
        6: if (ex) ns = 0;
        7: if (ex) ns = wake ? 0 : (bus_req ? 8 : home);
           else if (wake) ns = 6;
           else if (!bus_req) ns = home;
        8: if (wake) ns = 0; else if (!bus_req) ns = home;
        default: ns = 0;
      endcase
      m_cnt = (warm(m_st) && warm(ns)) ? m_cnt + 1 : 0;
      if (m_st == 0 && ns == 4) m_quick = 0;
      if (m_st == 0 && ns == 5) m_quick = 1;
      if (reg_we) m_ctl = reg_wdata;
      m_st    = ns;
      e_osc   = (ns == 4 || ns == 5) ? 0 : 1;
      e_run   = (ns <= 2) ? 1 : 0;
      e_ready = (ns == 0) ? 1 : 0;
      e_grant = (ns == 8 || (bus_req && awake(ns))) ? 1 : 0;
      e_st    = ns;
    end
  endtask

  task automatic chk(string tag, int act, int exp_v);
    n_cmp++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp_v);
    end
  endtask

  task automatic compare_all();
    chk("R3 mode_status", int'(mode_status), e_st);
    chk("R5 osc_en", int'(osc_en), e_osc);
    chk("R7 clk_run", int'(clk_run), e_run);
    chk("R7 ready", int'(ready), e_ready);
    chk("R8 bus_grant_ok", int'(bus_grant_ok), e_grant);
    chk("R2 div_bypass", int'(div_bypass), int'(m_ctl[0]));
    chk("R11 low_drive", int'(low_drive), int'(m_ctl[4]));
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    reg_we = 1'b0; sleep_exec = 1'b0; wake = 1'b0;
  endtask

  task automatic wr(logic [4:0] d);
    reg_we = 1'b1; reg_wdata = d; tick();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    rst = 1'b1; tick(); tick();
    rst = 1'b0; tick();
    // R1 reset state
    chk("R1 status", int'(mode_status), 0);
    chk("R1 osc_en", int'(osc_en), 1);
    chk("R1 clk_run", int'(clk_run), 1);
    chk("R1 ready", int'(ready), 1);
    chk("R1 div", int'(div_bypass), 0);
    chk("R1 grant", int'(bus_grant_ok), 0);
    // R2, R11
    wr(5'b10001);
    chk("R2 div_bypass", int'(div_bypass), 1);
    chk("R11 low_drive", int'(low_drive), 1);
    wr(5'b00000);
    // R10
    bus_req = 1'b1; tick();
    chk("R10 grant follows", int'(bus_grant_ok), 1);
    bus_req = 1'b0; tick();
    chk("R10 grant drops", int'(bus_grant_ok), 0);
    // R3 sleep, R12 ignored strobe
    sleep_exec = 1'b1; io_stop = 1'b0; tick();
    chk("R3 sleep", int'(mode_status), 1);
    sleep_exec = 1'b1; io_stop = 1'b1; tick();
    chk("R12 strobe ignored", int'(mode_status), 1);
    wake = 1'b1; tick();
    chk("R3 sleep wake", int'(mode_status), 0);
    wake = 1'b1; tick();
    chk("R12 wake in run", int'(mode_status), 0);
    sleep_exec = 1'b1; io_stop = 1'b1; tick();
    chk("R3 system stop", int'(mode_status), 2);
    chk("R3 clock on", int'(clk_run), 1);
    wake = 1'b1; tick();
    // R4 idle
    wr(5'b00010);
    sleep_exec = 1'b1; io_stop = 1'b1; tick();
    chk("R4 idle", int'(mode_status), 3);
    chk("R4 idle osc", int'(osc_en), 1);
    chk("R4 idle gate", int'(clk_run), 0);
    wake = 1'b1; tick();
    chk("R4 fast wake", int'(ready), 1);
    // R6 quick standby
    wr(5'b00110);
    sleep_exec = 1'b1; io_stop = 1'b1; tick();
    chk("R6 quick standby", int'(mode_status), 5);
    chk("R6 osc off", int'(osc_en), 0);
    wake = 1'b1; tick();
    chk("R7 restart gate", int'(clk_run), 0);
    chk("R5 restart osc", int'(osc_en), 1);
    repeat (SHORT - 1) tick();
    chk("R6 still settling", int'(ready), 0);
    tick();
    chk("R6 ready after short", int'(ready), 1);
    // R9 no bus wake
    wr(5'b00100);
    sleep_exec = 1'b1; io_stop = 1'b1; tick();
    chk("R5 standby", int'(mode_status), 4);
    bus_req = 1'b1;
    repeat (LONG + 5) tick();
    chk("R9 status", int'(mode_status), 4);
    chk("R9 osc", int'(osc_en), 0);
    chk("R9 grant", int'(bus_grant_ok), 0);
    bus_req = 1'b0;
    // R8 bus warm-up
    wr(5'b01100);
    bus_req = 1'b1; tick();
    chk("R8 warmup", int'(mode_status), 7);
    repeat (LONG - 1) tick();
    chk("R8 no early grant", int'(bus_grant_ok), 0);
    tick();
    chk("R8 grant", int'(bus_grant_ok), 1);
    bus_req = 1'b0; tick();
    chk("R8 back to standby", int'(mode_status), 4);
    chk("R8 osc off", int'(osc_en), 0);
    // R5 long restart
    wake = 1'b1; tick();
    repeat (LONG - 1) tick();
    chk("R5 still settling", int'(ready), 0);
    tick();
    chk("R5 ready after long", int'(ready), 1);
    // random phase
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(0, 39) == 0) begin
        reg_we = 1'b1; reg_wdata = 5'($urandom_range(0, 31));
      end
      if ($urandom_range(0, 9) == 0) begin
        sleep_exec = 1'b1; io_stop = 1'($urandom_range(0, 1));
      end
      if ($urandom_range(0, 59) == 0) wake = 1'b1;
      if ($urandom_range(0, 29) == 0) bus_req = ~bus_req;
      rst = ($urandom_range(0, 2999) == 0);
      tick();
    end
    rst = 1'b0;
    finish_run();
  end

endmodule